// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block brings a single-data-rate SDRAM from power-on to a usable state. After reset it holds the clock enable low and keeps every command pin deselected for a configurable settling time. It then plays a fixed script: one NOP, one precharge of all banks, a run of auto-refresh commands, and a mode-register load. Each command occupies one clock cycle. The gap after each command is set by its own timing parameter, and the bus carries NOP during each gap.

Once the mode-load time has passed after the mode-register load, the block raises a ready flag and keeps it high. From then on a distributed refresh timer produces a one-cycle refresh request every `refresh_period` cycles, for the access logic downstream. A port sets the reload value so that it can follow the clock rate. The package offers a helper that derives this value from 32 ms and 2048 rows, which gives 1562 at 100 MHz. Data transfers are not part of this block.

Top module: `sdram_bringup`

## Requirements
- R1: Reset is synchronous. After reset is released, `cke` stays 0 for exactly `POWERUP_CYCLES` cycles. During that time `{cs_n,ras_n,cas_n,we_n}` = 4'b1111 and `addr` = 0. `cke` then goes to 1 and stays at 1 until the next reset.
- R2: The first command is NOP (pins 4'b0111), driven in the first cycle with `cke` = 1.
- R3: `T_NOP` cycles after the NOP, a precharge-all (pins 4'b0010) is issued with `addr` bit `AP_BIT` (10) = 1 and all other address bits 0.
- R4: `T_RP` cycles after the precharge, exactly `REFRESH_COUNT` auto-refresh commands (pins 4'b0001, `addr` 0) follow, each `T_RFC` cycles after the previous one.
- R5: `T_RFC` cycles after the last refresh, a mode-register load (pins 4'b0000) is issued with `ba` = 0. Its `addr` is: bits[2:0] = 000 (burst length 1), bit 3 = 0 (sequential), bits[6:4] = `CAS_LAT`, bits[8:7] = 00, bit 9 = 1 (single-location writes), and all higher bits 0. This is 0x230 for CAS latency 3.
- R6: In every other cycle with `cke` = 1, the pins show NOP (4'b0111) with `addr` = 0, both in the gaps and after the mode load. `ba` is always 0.
- R7: `ready` rises exactly `T_MRD` cycles after the mode-register load and then stays high until reset.
- R8: While `ready` is 0, `refresh_req` is 0. The first one-cycle `refresh_req` comes `refresh_period` cycles after `ready` rises, and the next ones every `refresh_period` cycles after that (`refresh_period` ≥ 1).
- R9: A reset during operation returns the block to the power-up state in the next cycle: `cke`, `ready` and `refresh_req` are 0 and the pins are deselected. The full script then starts again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_period | input | REF_W | Refresh timer reload, in cycles |
| cke | output | 1 | SDRAM clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Row address bus |
| ready | output | 1 | Initialization complete |
| refresh_req | output | 1 | One-cycle refresh request |

## Verification
The bench builds the block with a 20-cycle power-up wait in place of the 20000-cycle default. The other timings keep their defaults: 2-cycle NOP gap, 5-cycle precharge time, 11-cycle refresh time, 2-cycle mode-load time and eight refreshes. With this setup the whole script, about 117 cycles, can be compared cycle by cycle against an arithmetic model of every pin. The bench repeats that comparison for refresh periods of 1, 2, 3, 7 and 13, which covers a request in every cycle and several spacings. It also applies a reset after `ready` is high to test the restart.

// File: rtl/sdram_bringup_pkg.sv
package sdram_bringup_pkg;

  // Internal step codes; the numeric values are the init mode numbering.
  typedef enum logic [2:0] {
    MODE_NORMAL    = 3'd0,
    MODE_NOP       = 3'd1,
    MODE_PRECHARGE = 3'd2,
    MODE_LOADMODE  = 3'd3,
    MODE_AUTOREF   = 3'd4,
    MODE_EXTLOAD   = 3'd5
  } init_mode_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_DESEL = 4'b1111;
  localparam logic [3:0] PINS_NOP   = 4'b0111;
  localparam logic [3:0] PINS_PRE   = 4'b0010;
  localparam logic [3:0] PINS_REF   = 4'b0001;
  localparam logic [3:0] PINS_MRS   = 4'b0000;

  function automatic logic [3:0] mode_pins(init_mode_e m);
    case (m)
      MODE_PRECHARGE: return PINS_PRE;
      MODE_AUTOREF:   return PINS_REF;
      MODE_LOADMODE:  return PINS_MRS;
      default:        return PINS_NOP;
    endcase
  endfunction

  // Mode word: BL=1, sequential, given CAS latency, single-location writes.
  function automatic logic [15:0] mode_word(int cas_lat);
    logic [15:0] w;
    w = '0;
    w[6:4] = 3'(cas_lat);
    w[9]   = 1'b1;
    return w;
  endfunction

  // Refresh reload: 32 ms spread over 2048 rows.
  function automatic int refresh_reload(int clk_khz);
    return (32 * clk_khz) / 2048;
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdr_step_timer.sv
module sdr_step_timer #(
  parameter int W       = 16,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= W'(RST_VAL);
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdr_refresh_timer.sv
module sdr_refresh_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] period,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  assign last = period - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (cnt == last) begin
      cnt   <= '0;
      pulse <= 1'b1;
    end else begin
      cnt   <= cnt + 1'b1;
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/sdram_bringup.sv
module sdram_bringup #(
  parameter int POWERUP_CYCLES = 20000,
  parameter int T_NOP          = 2,
  parameter int T_RP           = 5,
  parameter int T_RFC          = 11,
  parameter int T_MRD          = 2,
  parameter int REFRESH_COUNT  = 8,
  parameter int CAS_LAT        = 3,
  parameter int ROW_W          = 12,
  parameter int BANK_W         = 1,
  parameter int AP_BIT         = 10,
  parameter int REF_W          = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REF_W-1:0]  refresh_period,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic              ready,
  output logic              refresh_req
);
  import sdram_bringup_pkg::*;

  localparam int MAX_GAP = max2(max2(POWERUP_CYCLES, T_NOP),
                                max2(max2(T_RP, T_RFC), T_MRD));
  localparam int GAP_W   = $clog2(MAX_GAP + 1);
  localparam int RC_W    = $clog2(REFRESH_COUNT + 1);
  localparam logic [15:0]      MODE_FULL = mode_word(CAS_LAT);
  localparam logic [ROW_W-1:0] MODE_WORD = MODE_FULL[ROW_W-1:0];
  localparam logic [ROW_W-1:0] AP_WORD   = ROW_W'(1) << AP_BIT;

  init_mode_e       step;
  logic             gap_zero;
  logic             issue;
  logic [GAP_W-1:0] gap_val;
  logic [RC_W-1:0]  ref_left;
  logic [3:0]       pins;

  // Gap that follows the command about to be issued.
  always_comb begin
    issue = gap_zero && (step != MODE_NORMAL);
    case (step)
      MODE_NOP:       gap_val = GAP_W'(T_NOP - 1);
      MODE_PRECHARGE: gap_val = GAP_W'(T_RP - 1);
      MODE_AUTOREF:   gap_val = GAP_W'(T_RFC - 1);
      MODE_LOADMODE:  gap_val = GAP_W'(T_MRD - 1);
      default:        gap_val = '0;
    endcase
  end

  sdr_step_timer #(
    .W       (GAP_W),
    .RST_VAL (POWERUP_CYCLES - 1)
  ) u_gap (
    .clk      (clk),
    .rst      (rst),
    .load     (issue),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      step     <= MODE_NOP;
      cke      <= 1'b0;
      pins     <= PINS_DESEL;
      addr     <= '0;
      ready    <= 1'b0;
      ref_left <= RC_W'(REFRESH_COUNT - 1);
    end else begin
      if (issue) begin
        cke  <= 1'b1;
        pins <= mode_pins(step);
        case (step)
          MODE_PRECHARGE: addr <= AP_WORD;
          MODE_LOADMODE:  addr <= MODE_WORD;
          default:        addr <= '0;
        endcase
        case (step)
          MODE_NOP:       step <= MODE_PRECHARGE;
          MODE_PRECHARGE: step <= MODE_AUTOREF;
          MODE_AUTOREF: begin
            if (ref_left == '0) step <= MODE_LOADMODE;
            else                ref_left <= ref_left - 1'b1;
          end
          default:        step <= MODE_NORMAL;
        endcase
      end else begin
        pins <= cke ? PINS_NOP : PINS_DESEL;
        addr <= '0;
      end
      if (step == MODE_NORMAL && gap_zero)
        ready <= 1'b1;
    end
  end

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign ba = '0;

  sdr_refresh_timer #(
    .W (REF_W)
  ) u_refresh (
    .clk    (clk),
    .rst    (rst),
    .en     (ready),
    .period (refresh_period),
    .pulse  (refresh_req)
  );
endmodule

// File: rtl/sdram_bringup_checker.sv
module sdram_bringup_checker #(
  parameter int T_NOP         = 2,
  parameter int T_RP          = 5,
  parameter int T_RFC         = 11,
  parameter int T_MRD         = 2,
  parameter int REFRESH_COUNT = 8,
  parameter int CAS_LAT       = 3,
  parameter int ROW_W         = 12,
  parameter int BANK_W        = 1,
  parameter int AP_BIT        = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cke,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BANK_W-1:0] ba,
  input logic [ROW_W-1:0]  addr,
  input logic              ready,
  input logic              refresh_req
);
  import sdram_bringup_pkg::*;

  localparam logic [15:0]      MW_FULL   = mode_word(CAS_LAT);
  localparam logic [ROW_W-1:0] MODE_WORD = MW_FULL[ROW_W-1:0];

  logic [3:0]  pins;
  logic        cke_d, is_pre, is_ref, is_mrs, is_cmd;
  logic [15:0] since;
  logic        last_pre, mrs_seen;
  logic [7:0]  ref_cnt;

  assign pins   = {cs_n, ras_n, cas_n, we_n};
  assign is_pre = cke && pins == PINS_PRE;
  assign is_ref = cke && pins == PINS_REF;
  assign is_mrs = cke && pins == PINS_MRS;
  assign is_cmd = is_pre || is_ref || is_mrs || (cke && !cke_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_d    <= 1'b0;
      since    <= '0;
      last_pre <= 1'b0;
      mrs_seen <= 1'b0;
      ref_cnt  <= '0;
    end else begin
      cke_d <= cke;
      if (is_cmd)              since <= 16'd1;
      else if (since != '1)    since <= since + 1'b1;
      if (is_cmd)              last_pre <= is_pre;
      if (is_mrs)              mrs_seen <= 1'b1;
      if (is_ref)              ref_cnt <= ref_cnt + 1'b1;
    end
  end

  assert_cke_hold_R1: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);
  assert_quiet_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !cke |-> (pins == PINS_DESEL && addr == '0));
  assert_first_nop_R2: assert property (@(posedge clk) disable iff (rst)
    (cke && !cke_d) |-> pins == PINS_NOP);
  assert_pre_a10_R3: assert property (@(posedge clk) disable iff (rst)
    is_pre |-> (addr[AP_BIT] && since >= 16'(T_NOP)));
  assert_ref_spacing_R4: assert property (@(posedge clk) disable iff (rst)
    is_ref |-> (since >= (last_pre ? 16'(T_RP) : 16'(T_RFC))));
  assert_ref_count_R4: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (ref_cnt == 8'(REFRESH_COUNT) && since >= 16'(T_RFC)));
  assert_mode_word_R5: assert property (@(posedge clk) disable iff (rst)
    is_mrs |-> (addr == MODE_WORD && ba == '0));
  assert_ready_after_mrs_R7: assert property (@(posedge clk) disable iff (rst)
    (ready && !$past(ready)) |-> (mrs_seen && since >= 16'(T_MRD)));
  assert_ready_hold_R7: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_req_gated_R8: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> ready);
endmodule

bind sdram_bringup sdram_bringup_checker #(
  .T_NOP         (T_NOP),
  .T_RP          (T_RP),
  .T_RFC         (T_RFC),
  .T_MRD         (T_MRD),
  .REFRESH_COUNT (REFRESH_COUNT),
  .CAS_LAT       (CAS_LAT),
  .ROW_W         (ROW_W),
  .BANK_W        (BANK_W),
  .AP_BIT        (AP_BIT)
) u_checker (
  .clk         (clk),
  .rst         (rst),
  .cke         (cke),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .ba          (ba),
  .addr        (addr),
  .ready       (ready),
  .refresh_req (refresh_req)
);

// File: tb/sdram_bringup_test.sv
module sdram_bringup_test;
  localparam int PU    = 20;
  localparam int TNOP  = 2;
  localparam int TRP   = 5;
  localparam int TRFC  = 11;
  localparam int TMRD  = 2;
  localparam int NREF  = 8;
  localparam int ROWW  = 12;
  localparam int REFW  = 16;

  localparam int T_PRE = PU + TNOP;
  localparam int T_REF = T_PRE + TRP;
  localparam int T_MRS = T_REF + NREF * TRFC;
  localparam int T_RDY = T_MRS + TMRD;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [REFW-1:0] refresh_period = 16'd4;
  logic            cke, cs_n, ras_n, cas_n, we_n, ready, refresh_req;
  logic [0:0]      ba;
  logic [ROWW-1:0] addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  sdram_bringup #(
    .POWERUP_CYCLES (PU),
    .T_NOP          (TNOP),
    .T_RP           (TRP),
    .T_RFC          (TRFC),
    .T_MRD          (TMRD),
    .REFRESH_COUNT  (NREF),
    .CAS_LAT        (3),
    .ROW_W          (ROWW),
    .BANK_W         (1),
    .AP_BIT         (10),
    .REF_W          (REFW)
  ) uut (
    .clk            (clk),
    .rst            (rst),
    .refresh_period (refresh_period),
    .cke            (cke),
    .cs_n           (cs_n),
    .ras_n          (ras_n),
    .cas_n          (cas_n),
    .we_n           (we_n),
    .ba             (ba),
    .addr           (addr),
    .ready          (ready),
    .refresh_req    (refresh_req)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // Expected pins/address at sample index c (c = cycles after reset release).
  task automatic expect_at(int c, output logic [3:0] p, output int a,
                           output string tag);
    a = 0;
    if (c < PU)              begin p = 4'b1111; tag = "R1"; end
    else if (c == PU)        begin p = 4'b0111; tag = "R2"; end
    else if (c == T_PRE)     begin p = 4'b0010; a = 32'h400; tag = "R3"; end
    else if (c >= T_REF && c < T_MRS && ((c - T_REF) % TRFC) == 0)
                             begin p = 4'b0001; tag = "R4"; end
    else if (c == T_MRS)     begin p = 4'b0000; a = 32'h230; tag = "R5"; end
    else                     begin p = 4'b0111; tag = "R6"; end
  endtask

  task automatic run_case(int per);
    logic [3:0] ep;
    int         ea;
    string      tag;
    bit         ereq;
    refresh_period = 16'(per);
    do_reset();
    for (int c = 0; c < T_RDY + 4 * per + 3; c++) begin
      if (c > 0) @(negedge clk);
      expect_at(c, ep, ea, tag);
      chk(cke == (c >= PU), (c == PU) ? "R2" : "R1", "cke", cke, c >= PU);
      chk({cs_n, ras_n, cas_n, we_n} == ep, tag, "pins",
          {cs_n, ras_n, cas_n, we_n}, ep);
      chk(addr == ROWW'(ea), tag, "addr", addr, ea);
      chk(ba == 1'b0, "R6", "ba", ba, 0);
      chk(ready == (c >= T_RDY), "R7", "ready", ready, c >= T_RDY);
      ereq = (c >= T_RDY + per) && (((c - T_RDY) % per) == 0);
      chk(refresh_req == ereq, "R8", "refresh_req", refresh_req, ereq);
    end
  endtask

  task automatic mid_reset(int per);
    refresh_period = 16'(per);
    do_reset();
    repeat (T_RDY + per + 1) @(negedge clk);
    chk(ready == 1'b1, "R7", "ready before re-reset", ready, 1);
    rst = 1'b1;
    @(negedge clk);
    chk(cke == 1'b0, "R9", "cke after reset", cke, 0);
    chk(ready == 1'b0, "R9", "ready after reset", ready, 0);
    chk(refresh_req == 1'b0, "R9", "refresh_req after reset", refresh_req, 0);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R9", "pins after reset",
        {cs_n, ras_n, cas_n, we_n}, 4'hF);
    rst = 1'b0;
    for (int k = 1; k <= 3; k++) begin
      @(negedge clk);
      chk(cke == 1'b0, "R9", "cke during restart wait", cke, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=0 expected=1");
      summary();
    end
  end

  initial begin
    run_case(1);
    run_case(2);
    run_case(3);
    run_case(7);
    mid_reset(5);
    run_case(13);
    done = 1;
    summary();
  end
endmodule